// File: doc/BRIEF.md
# I2C Target Byte Engine with Service-Held Clock

This block lets a chip answer as a 7-bit-addressed target on a two-wire I2C bus. It watches the SCL and SDA pins through input samples and drives each wire only by pulling it low. It finds START and STOP conditions. It shifts in the byte that follows a START and compares the called address with an address set by the local host. When the address matches, the block acknowledges it and then moves data bytes in the direction given by the last bit of that byte.

The local host takes part in every byte. When a byte finishes, the block raises `irq` and keeps SCL low, so the bus master cannot go on. The host reads `rx_byte`, or loads `tx_byte` when the master is reading, and then pulses `irq_clr` to let the clock go. The bus therefore moves at the pace the host can service it. The block only works as a target: it does not take part in arbitration, extended addressing or broadcast calls.

Top module: `i2c_tgt_stretch`

## Requirements
- R1: After synchronous reset, both pull-low outputs are 0 (wires released), and `irq` and `is_read` are 0.
- R2: The first byte after a START holds the called address in bits 7..1, most significant bit first, and the direction in bit 0. After a matching address, `is_read` is 1 for direction 1 (master reads) and 0 for direction 0 (master writes).
- R3: The target pulls SDA low during the ninth clock only when the called address equals `own_addr`. On a mismatch SDA stays released for the rest of the transfer and `irq` never rises.
- R4: In a write transfer, each data byte is shifted in most significant bit first and shown on `rx_byte`. With `ack_en` = 1 the byte is acknowledged by pulling SDA low during its ninth clock.
- R5: In a read transfer, the byte on `tx_byte` at the moment `irq_clr` is pulsed is sent most significant bit first. The target releases SDA during the ninth clock so that the master can acknowledge.
- R6: After each acknowledged address byte, each received data byte, and each sent byte that the master acknowledges, `irq` is set and SCL is held low until `irq_clr` is pulsed. Shortly after the pulse, SCL is released.
- R7: The target changes its SDA drive only while SCL is low.
- R8: If the master does not acknowledge a sent byte, no `irq` is raised and SDA stays released until the next START. Any further clocks read as all ones.
- R9: With `ack_en` = 0, a received data byte is not acknowledged (SDA released on the ninth clock). The byte is still captured on `rx_byte` and `irq` is still raised.
- R10: A START or repeated START at any point restarts the address phase. A STOP at any point returns the target to idle with both wires released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Sampled level of the SCL wire |
| sda_in | input | 1 | Sampled level of the SDA wire |
| scl_pull | output | 1 | 1 pulls SCL low (clock hold) |
| sda_pull | output | 1 | 1 pulls SDA low (acknowledge or data 0) |
| own_addr | input | 7 | Address this target answers to |
| tx_byte | input | 8 | Byte to send next in a read transfer |
| rx_byte | output | 8 | Last data byte received |
| ack_en | input | 1 | 1 acknowledges received data bytes |
| is_read | output | 1 | Direction of the current transfer, 1 = master reads |
| irq | output | 1 | Byte-complete flag, SCL is held while it is 1 |
| irq_clr | input | 1 | One-cycle strobe that clears `irq` and frees SCL |

## Verification
The hardest situation to reach from the ports is a master that has already let go of SCL while the target still holds it. Only a bus model that behaves as a wired AND, and waits for the wire to actually rise, can show that the hold is real. The bench models both wires this way. A host process services each flag only after a 40-cycle delay, and during that delay it watches the SCL wire stay low. A second hard case is a master that not-acknowledges a byte and then keeps clocking without a START. The bench does this by reading a whole extra byte and expecting all ones with no flag raised.

// File: rtl/i2c_tgt_pkg.sv
// Package: shared types for the I2C target byte engine.
// Assumes: one state encoding is used by the engine and its assertions.
package i2c_tgt_pkg;

    // Byte engine phases.
    typedef enum logic [2:0] {
        ST_IDLE,   // released, waiting for a START
        ST_ADDR,   // shifting in the called address and direction
        ST_AACK,   // driving the address acknowledge
        ST_RX,     // shifting in a data byte from the master
        ST_RACK,   // acknowledge slot of a received byte
        ST_TX,     // shifting out a data byte to the master
        ST_TACK,   // sampling the master's acknowledge
        ST_HOLD    // byte done, clock held until the host services it
    } tgt_state_t;

endpackage

// File: rtl/i2c_tgt_sync.sv
// Module: multi-bit level synchroniser.
// Brings asynchronous wire levels into the clk domain through a chain of
// STAGES flip-flops per line.
// Assumes: each line idles high, so the chains reset to 1.
module i2c_tgt_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] synced
);

    genvar gi;
    generate
        for (gi = 0; gi < LINES; gi++) begin : g_line
            logic [STAGES-1:0] chain;

            // Shift the raw level through the chain for this line.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], raw[gi]};
            end

            assign synced[gi] = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/i2c_tgt_cond.sv
// Module: bus condition detector.
// Compares successive synchronised samples of SCL and SDA. It reports the SCL
// edges, START (SDA falls while SCL stays high) and STOP (SDA rises while SCL
// stays high).
// Assumes: its inputs are already synchronous to clk.
module i2c_tgt_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic scl_q;
    logic sda_q;

    // Keep the previous sample of each wire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // Decode edges and bus conditions from the two samples.
    always_comb begin
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/i2c_tgt_engine.sv
// Module: target byte engine.
// Receives the address byte, acknowledges a match, then receives or sends
// data bytes. It holds SCL low after each byte until the host clears the flag.
// Assumes: event inputs come from the condition detector. SDA changes happen
// on detected SCL falls, or while the engine itself holds SCL low.
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [ADDR_W:0]   tx_byte,
    input  logic              ack_en,
    input  logic              irq_clr,
    output logic [ADDR_W:0]   rx_byte,
    output logic              is_read,
    output logic              irq,
    output logic              scl_pull,
    output logic              sda_pull
);

    localparam int DATA_W = ADDR_W + 1;
    localparam int CNT_W  = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    tgt_state_t        state;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] shreg;
    logic              sda_drv;
    logic              scl_hold;
    logic              dir_q;
    logic              mack_q;
    logic              next_tx;

    // Main byte state machine: bit counting, shifting, acknowledges and hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            shreg   <= '0;
            sda_drv <= 1'b0;
            dir_q   <= 1'b0;
            mack_q  <= 1'b0;
            next_tx <= 1'b0;
            rx_byte <= '0;
        end else if (start_det) begin
            state   <= ST_ADDR;
            cnt     <= '0;
            sda_drv <= 1'b0;
        end else if (stop_det) begin
            state   <= ST_IDLE;
            sda_drv <= 1'b0;
        end else begin
            case (state)
                ST_ADDR: begin
                    if (scl_rise && cnt != LAST) begin
                        shreg <= {shreg[DATA_W-2:0], sda_s};
                        cnt   <= cnt + ONE;
                    end else if (scl_fall && cnt == LAST) begin
                        if (shreg[DATA_W-1:1] == own_addr) begin
                            sda_drv <= 1'b1;
                            dir_q   <= shreg[0];
                            state   <= ST_AACK;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_fall) begin
                        sda_drv <= 1'b0;
                        next_tx <= dir_q;
                        state   <= ST_HOLD;
                    end
                end
                ST_RX: begin
                    if (scl_rise && cnt != LAST) begin
                        shreg <= {shreg[DATA_W-2:0], sda_s};
                        cnt   <= cnt + ONE;
                    end else if (scl_fall && cnt == LAST) begin
                        rx_byte <= shreg;
                        sda_drv <= ack_en;
                        state   <= ST_RACK;
                    end
                end
                ST_RACK: begin
                    if (scl_fall) begin
                        sda_drv <= 1'b0;
                        next_tx <= 1'b0;
                        state   <= ST_HOLD;
                    end
                end
                ST_HOLD: begin
                    if (irq_clr) begin
                        cnt <= '0;
                        if (next_tx) begin
                            shreg   <= tx_byte;
                            sda_drv <= ~tx_byte[DATA_W-1];
                            state   <= ST_TX;
                        end else begin
                            state <= ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise && cnt != LAST) begin
                        cnt <= cnt + ONE;
                    end else if (scl_fall && cnt == LAST) begin
                        sda_drv <= 1'b0;
                        state   <= ST_TACK;
                    end else if (scl_fall && cnt != '0) begin
                        shreg   <= {shreg[DATA_W-2:0], 1'b0};
                        sda_drv <= ~shreg[DATA_W-2];
                    end
                end
                ST_TACK: begin
                    if (scl_rise) begin
                        mack_q <= ~sda_s;
                    end else if (scl_fall) begin
                        if (mack_q) begin
                            next_tx <= 1'b1;
                            state   <= ST_HOLD;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // SCL hold follows the hold phase one cycle late, so that SDA settles
    // before the clock is let go.
    always_ff @(posedge clk) begin
        if (!rst_n) scl_hold <= 1'b0;
        else        scl_hold <= (state == ST_HOLD);
    end

    assign irq      = (state == ST_HOLD);
    assign is_read  = dir_q;
    assign scl_pull = scl_hold;
    assign sda_pull = sda_drv;

    // R6: an unserviced flag keeps the clock held.
    a_r6_hold_until_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> scl_pull);

    // R6: servicing the flag frees the clock.
    a_r6_release_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && irq_clr) |=> ##1 !scl_pull);

    // R7: SDA drive changes only on a low SCL sample, bus conditions aside.
    a_r7_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(start_det) && !$past(stop_det) && (sda_drv != $past(sda_drv)))
        |-> !$past(scl_s));

    // R3: the address acknowledge slot is only entered on a match.
    a_r3_ack_only_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_AACK) |-> (shreg[DATA_W-1:1] == own_addr));

    // R8: in idle the target leaves both wires alone.
    a_r8_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!sda_pull && !scl_pull));

endmodule

// File: rtl/i2c_tgt_stretch.sv
// Module: I2C target with a host-serviced clock hold (top).
// Synchronises both wires, detects bus conditions and runs the byte engine.
// Assumes: clk is many times faster than SCL. The pull outputs drive
// open-drain pads, where 1 pulls the wire low.
module i2c_tgt_stretch #(
    parameter int ADDR_W      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_pull,
    output logic              sda_pull,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [ADDR_W:0]   tx_byte,
    output logic [ADDR_W:0]   rx_byte,
    input  logic              ack_en,
    output logic              is_read,
    output logic              irq,
    input  logic              irq_clr
);

    logic [1:0] lines_s;
    logic       scl_rise;
    logic       scl_fall;
    logic       start_det;
    logic       stop_det;

    i2c_tgt_sync #(
        .LINES  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    ({sda_in, scl_in}),
        .synced (lines_s)
    );

    i2c_tgt_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (lines_s[0]),
        .sda_s     (lines_s[1]),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_tgt_engine #(
        .ADDR_W (ADDR_W)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (lines_s[0]),
        .sda_s     (lines_s[1]),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .own_addr  (own_addr),
        .tx_byte   (tx_byte),
        .ack_en    (ack_en),
        .irq_clr   (irq_clr),
        .rx_byte   (rx_byte),
        .is_read   (is_read),
        .irq       (irq),
        .scl_pull  (scl_pull),
        .sda_pull  (sda_pull)
    );

endmodule

// File: tb/i2c_tgt_stretch_test.sv
`timescale 1ns/1ps
module i2c_tgt_stretch_test;

    localparam int HP      = 16;
    localparam int SVC_DLY = 40;
    localparam logic [6:0] OWN = 7'h5A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl_low = 1'b0;
    logic       m_sda_low = 1'b0;
    logic       scl_line;
    logic       sda_line;
    logic       scl_pull;
    logic       sda_pull;
    logic [7:0] tx_byte = 8'h00;
    logic [7:0] rx_byte;
    logic       ack_en = 1'b1;
    logic       is_read;
    logic       irq;
    logic       irq_clr = 1'b0;

    int errors = 0;
    int checks = 0;
    int svc_cnt = 0;
    int stretch_bad = 0;
    int sda_bad = 0;
    int tx_idx = 0;
    logic [7:0] tx_arr [0:3];
    logic [7:0] rx_log [0:63];
    logic       prev_sda_pull = 1'b0;

    always #4 clk = ~clk;

    assign scl_line = !(m_scl_low || scl_pull);
    assign sda_line = !(m_sda_low || sda_pull);

    i2c_tgt_stretch uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_line),
        .sda_in   (sda_line),
        .scl_pull (scl_pull),
        .sda_pull (sda_pull),
        .own_addr (OWN),
        .tx_byte  (tx_byte),
        .rx_byte  (rx_byte),
        .ack_en   (ack_en),
        .is_read  (is_read),
        .irq      (irq),
        .irq_clr  (irq_clr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R7 monitor: target SDA drive must not move while SCL is high.
    always @(negedge clk) begin
        if (rst_n && (sda_pull != prev_sda_pull) && scl_line) sda_bad++;
        prev_sda_pull <= sda_pull;
    end

    // Local host: services each flag after a delay, watching SCL stay held.
    always begin
        @(negedge clk);
        if (rst_n && irq) begin
            rx_log[svc_cnt % 64] = rx_byte;
            svc_cnt++;
            for (int k = 0; k < SVC_DLY; k++) begin
                @(negedge clk);
                if (scl_line) stretch_bad++;
            end
            if (!scl_pull) stretch_bad++;
            if (is_read) begin
                tx_byte = tx_arr[tx_idx % 4];
                tx_idx++;
            end
            irq_clr = 1'b1;
            @(negedge clk);
            irq_clr = 1'b0;
        end
    end

    task automatic hp();
        repeat (HP) @(negedge clk);
    endtask

    task automatic scl_up();
        m_scl_low = 1'b0;
        while (!scl_line) @(negedge clk);
    endtask

    task automatic m_start();
        m_sda_low = 1'b0; m_scl_low = 1'b0; hp();
        m_sda_low = 1'b1; hp();
        m_scl_low = 1'b1; hp();
    endtask

    task automatic m_rstart();
        m_sda_low = 1'b0; hp();
        scl_up(); hp();
        m_sda_low = 1'b1; hp();
        m_scl_low = 1'b1; hp();
    endtask

    task automatic m_stop();
        m_sda_low = 1'b1; hp();
        scl_up(); hp();
        m_sda_low = 1'b0; hp();
    endtask

    task automatic wbit(input logic b);
        m_sda_low = !b; hp();
        scl_up(); hp();
        m_scl_low = 1'b1; hp();
    endtask

    task automatic rbit(output logic b);
        m_sda_low = 1'b0; hp();
        scl_up();
        repeat (HP/2) @(negedge clk);
        b = sda_line;
        repeat (HP/2) @(negedge clk);
        m_scl_low = 1'b1; hp();
    endtask

    task automatic wbyte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) wbit(d[i]);
        rbit(b);
        ack = !b;
    endtask

    task automatic rbyte(input logic give_ack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            rbit(b);
            d[i] = b;
        end
        wbit(!give_ack);
    endtask

    task automatic t_reset();
        chk(scl_pull == 1'b0, "R1 scl_pull", scl_pull, 0);
        chk(sda_pull == 1'b0, "R1 sda_pull", sda_pull, 0);
        chk(irq == 1'b0, "R1 irq", irq, 0);
        chk(is_read == 1'b0, "R1 is_read", is_read, 0);
    endtask

    task automatic t_write();
        logic ack;
        int base;
        base = svc_cnt;
        m_start();
        wbyte({OWN, 1'b0}, ack);
        chk(ack == 1'b1, "R3 address ack", ack, 1);
        chk(is_read == 1'b0, "R2 write direction", is_read, 0);
        wbyte(8'hC3, ack);
        chk(ack == 1'b1, "R4 data ack 1", ack, 1);
        wbyte(8'h01, ack);
        chk(ack == 1'b1, "R4 data ack 2", ack, 1);
        m_stop();
        chk(svc_cnt - base == 3, "R6 flag per byte", svc_cnt - base, 3);
        chk(rx_log[(base+1) % 64] == 8'hC3, "R4 first byte", rx_log[(base+1) % 64], 8'hC3);
        chk(rx_log[(base+2) % 64] == 8'h01, "R4 second byte", rx_log[(base+2) % 64], 8'h01);
        chk(stretch_bad == 0, "R6 clock held while flag set", stretch_bad, 0);
    endtask

    task automatic t_badaddr();
        logic ack;
        int base;
        base = svc_cnt;
        m_start();
        wbyte({7'h5B, 1'b0}, ack);
        chk(ack == 1'b0, "R3 mismatch no ack", ack, 0);
        wbyte(8'h00, ack);
        chk(ack == 1'b0, "R3 mismatch data released", ack, 0);
        m_stop();
        chk(svc_cnt == base, "R3 mismatch no flag", svc_cnt - base, 0);
    endtask

    task automatic t_read();
        logic ack;
        logic [7:0] d;
        int base;
        base = svc_cnt;
        tx_arr[0] = 8'h96; tx_arr[1] = 8'h3F; tx_idx = 0;
        m_start();
        wbyte({OWN, 1'b1}, ack);
        chk(ack == 1'b1, "R3 read address ack", ack, 1);
        chk(is_read == 1'b1, "R2 read direction", is_read, 1);
        rbyte(1'b1, d);
        chk(d == 8'h96, "R5 first sent byte", d, 8'h96);
        rbyte(1'b0, d);
        chk(d == 8'h3F, "R5 second sent byte", d, 8'h3F);
        chk(svc_cnt - base == 2, "R8 no flag after nack", svc_cnt - base, 2);
        rbyte(1'b0, d);
        chk(d == 8'hFF, "R8 released after nack", d, 8'hFF);
        chk(svc_cnt - base == 2, "R8 no flag on extra clocks", svc_cnt - base, 2);
        m_stop();
    endtask

    task automatic t_noack();
        logic ack;
        int base;
        base = svc_cnt;
        ack_en = 1'b0;
        m_start();
        wbyte({OWN, 1'b0}, ack);
        chk(ack == 1'b1, "R9 address still acked", ack, 1);
        wbyte(8'h7E, ack);
        chk(ack == 1'b0, "R9 data not acked", ack, 0);
        m_stop();
        chk(svc_cnt - base == 2, "R9 flag still raised", svc_cnt - base, 2);
        chk(rx_log[(base+1) % 64] == 8'h7E, "R9 byte captured", rx_log[(base+1) % 64], 8'h7E);
        ack_en = 1'b1;
    endtask

    task automatic t_restart();
        logic ack;
        logic [7:0] d;
        m_start();
        wbit(1'b1); wbit(1'b0); wbit(1'b1);
        m_stop();
        repeat (4) @(negedge clk);
        chk(!irq && !sda_pull && !scl_pull, "R10 stop returns idle", {irq, sda_pull, scl_pull}, 0);
        m_start();
        wbit(1'b0); wbit(1'b1); wbit(1'b1); wbit(1'b0);
        m_rstart();
        wbyte({OWN, 1'b0}, ack);
        chk(ack == 1'b1, "R10 restart mid address", ack, 1);
        wbyte(8'h44, ack);
        chk(ack == 1'b1, "R10 data after restart", ack, 1);
        tx_arr[0] = 8'hA5; tx_idx = 0;
        m_rstart();
        wbyte({OWN, 1'b1}, ack);
        chk(ack == 1'b1, "R10 restart into read", ack, 1);
        rbyte(1'b0, d);
        chk(d == 8'hA5, "R10 read after restart", d, 8'hA5);
        m_stop();
        repeat (4) @(negedge clk);
        chk(!sda_pull && !scl_pull, "R10 idle after stop", {sda_pull, scl_pull}, 0);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_write();
        t_badaddr();
        t_read();
        t_noack();
        t_restart();
        chk(sda_bad == 0, "R7 sda moved with scl high", sda_bad, 0);
        chk(stretch_bad == 0, "R6 hold over all tests", stretch_bad, 0);
        finish_run();
    end

endmodule